// File: doc/BRIEF.md
# Brownout and Reset Output Sequencer

This block sits between two undervoltage comparators and the supply supervisor's output pins. One comparator reports that the supply has dropped below the upper warning level. The other reports that it has dropped below the lower reset level. A third input carries a manual reset request from a push-button stage. From these the block drives two active-low levels: a bad-power warning and a system reset.

Each comparator flag passes through its own glitch qualifier. A flag must stay high, without a break, for a selectable number of fast-tick cycles before it counts as a fault. Shorter dips are discarded. The reset output is driven by a hold timer. It stays asserted while its cause is present, and for a selectable number of millisecond ticks after the cause clears. Whenever reset is asserted, the warning is asserted as well, so no stray warning is seen during power-up.

Both time bases come in as single-cycle enable pulses. In use, the fast tick runs at about 1 MHz and the slow tick at about 1 kHz.

**Qualifier states** (`qual_state_t`):
- `Q_IDLE`: flag low. It goes to `Q_COUNT`, or straight to `Q_FAULT` when one tick already meets the width, as soon as the flag is high.
- `Q_COUNT`: counts ticks while the flag is high. It returns to `Q_IDLE` when the flag drops, and goes to `Q_FAULT` when the count reaches the width.
- `Q_FAULT`: returns to `Q_IDLE` on the first cycle the flag is low.

**Hold timer states** (`hold_state_t`):
- `H_HOLD`: cause active. It goes to `H_STRETCH` when the cause clears.
- `H_STRETCH`: counts slow ticks. It goes back to `H_HOLD` if the cause returns, and to `H_RELEASE` when the count reaches the limit.
- `H_RELEASE`: reset deasserted. It goes to `H_HOLD` when the cause appears.

Power-on reset places the timer in `H_STRETCH` with a zero count.

Top module: `supply_watch_seq`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` and `bad_pwr_n` are both 0. After `por_n` is released, reset stays asserted until one full timeout has run, counted from zero.
- R2: The glitch width is set by `glitch_sel`: 0 selects 4 fast ticks, 1 selects 6, 2 selects 10 and 3 selects 18. A qualifier reports a fault on the cycle after the width-th `fast_tick` cycle during which its flag was continuously high.
- R3: A flag that drops before reaching the width causes no output change, and the next high period starts counting from zero.
- R4: A qualified fault clears on the cycle after its flag goes low.
- R5: `sys_rst_n` goes to 0 on the cycle after the reset qualifier reports a fault or `man_req` is high.
- R6: The timeout is set by `hold_sel`: 0 selects 1 ms tick, 1 selects 25, 2 selects 100 and 3 selects 200. Once the cause has cleared, `sys_rst_n` returns to 1 on the cycle after that many `ms_tick` cycles. A tick in the cycle the cause clears does not count.
- R7: If the cause returns during the timeout, the count is discarded, and a fresh full timeout starts when the cause clears again.
- R8: `bad_pwr_n` is 0 whenever `sys_rst_n` is 0, and also whenever the warning qualifier reports a fault.
- R9: Counts advance only in cycles where the matching tick input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warn_uv | input | 1 | Supply below warning level (comparator flag, high = low supply) |
| rst_uv | input | 1 | Supply below reset level (comparator flag, high = low supply) |
| man_req | input | 1 | Manual reset request, high = requested |
| fast_tick | input | 1 | Glitch time-base enable pulse |
| ms_tick | input | 1 | Timeout time-base enable pulse |
| glitch_sel | input | 2 | Glitch width select (see R2) |
| hold_sel | input | 2 | Reset timeout select (see R6) |
| bad_pwr_n | output | 1 | Bad-power warning, active low |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The hold timer can see its cause return in the same cycle in which a slow tick would have completed the timeout. The reset qualifier can also clear its fault in the very cycle that the manual request rises. The bench provokes both collisions, first by aligning `rst_uv` and `man_req` edges with tick cycles at fixed offsets, and then through a long stretch of pseudo-random stimulus with dense ticks. A behavioural model built from counters and integers predicts both outputs, and its prediction is compared with the design on every cycle. In each collision the returning cause must win over the release, and the timeout must restart from zero.

// File: rtl/supply_watch_pkg.sv
package supply_watch_pkg;

    typedef enum logic [1:0] {
        Q_IDLE  = 2'd0,
        Q_COUNT = 2'd1,
        Q_FAULT = 2'd2
    } qual_state_t;

    typedef enum logic [1:0] {
        H_HOLD    = 2'd0,
        H_STRETCH = 2'd1,
        H_RELEASE = 2'd2
    } hold_state_t;

endpackage

// File: rtl/uv_qualifier.sv
module uv_qualifier
    import supply_watch_pkg::*;
#(
    parameter int W0 = 4,
    parameter int W1 = 6,
    parameter int W2 = 10,
    parameter int W3 = 18
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       tick_i,
    input  logic       flag_i,
    input  logic [1:0] sel_i,
    output logic       fault_o
);
    localparam int M01  = (W0 > W1) ? W0 : W1;
    localparam int M23  = (W2 > W3) ? W2 : W3;
    localparam int MAXW = (M01 > M23) ? M01 : M23;
    localparam int CW   = $clog2(MAXW + 1);

    qual_state_t   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] width;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        unique case (sel_i)
            2'd0:    width = CW'(W0);
            2'd1:    width = CW'(W1);
            2'd2:    width = CW'(W2);
            default: width = CW'(W3);
        endcase
    end

    assign cnt_inc = cnt_q + 1'b1;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q  <= Q_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            Q_IDLE: begin
                cnt_d = '0;
                if (flag_i) begin
                    if (tick_i) begin
                        cnt_d = CW'(1);
                        st_d  = (CW'(1) >= width) ? Q_FAULT : Q_COUNT;
                    end else begin
                        st_d = Q_COUNT;
                    end
                end
            end
            Q_COUNT: begin
                if (!flag_i) begin
                    st_d  = Q_IDLE;
                    cnt_d = '0;
                end else if (tick_i) begin
                    if (cnt_inc >= width) begin
                        st_d  = Q_FAULT;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            Q_FAULT: begin
                cnt_d = '0;
                if (!flag_i) st_d = Q_IDLE;
            end
            default: begin
                st_d  = Q_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    always_comb begin
        fault_o = (st_q == Q_FAULT);
    end

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
        !flag_i |=> !fault_o); // R4
    AST_FAULT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!por_n)
        $rose(fault_o) |-> ($past(flag_i) && $past(tick_i))); // R2

endmodule

// File: rtl/hold_timer.sv
module hold_timer
    import supply_watch_pkg::*;
#(
    parameter int T0 = 1,
    parameter int T1 = 25,
    parameter int T2 = 100,
    parameter int T3 = 200
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       tick_i,
    input  logic       cause_i,
    input  logic [1:0] sel_i,
    output logic       released_o
);
    localparam int M01  = (T0 > T1) ? T0 : T1;
    localparam int M23  = (T2 > T3) ? T2 : T3;
    localparam int MAXT = (M01 > M23) ? M01 : M23;
    localparam int CW   = $clog2(MAXT + 1);

    hold_state_t   st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        unique case (sel_i)
            2'd0:    limit = CW'(T0);
            2'd1:    limit = CW'(T1);
            2'd2:    limit = CW'(T2);
            default: limit = CW'(T3);
        endcase
    end

    assign cnt_inc = cnt_q + 1'b1;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q  <= H_STRETCH;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            H_HOLD: begin
                cnt_d = '0;
                if (!cause_i) st_d = H_STRETCH;
            end
            H_STRETCH: begin
                if (cause_i) begin
                    st_d  = H_HOLD;
                    cnt_d = '0;
                end else if (tick_i) begin
                    if (cnt_inc >= limit) begin
                        st_d  = H_RELEASE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            H_RELEASE: begin
                cnt_d = '0;
                if (cause_i) st_d = H_HOLD;
            end
            default: begin
                st_d  = H_HOLD;
                cnt_d = '0;
            end
        endcase
    end

    always_comb begin
        released_o = (st_q == H_RELEASE);
    end

    AST_CAUSE_BLOCKS_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        cause_i |=> !released_o); // R5
    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!por_n)
        $rose(released_o) |-> ($past(tick_i) && !$past(cause_i))); // R9
    AST_REASSERT_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $fell(released_o) |-> $past(cause_i)); // R7

endmodule

// File: rtl/supply_watch_seq.sv
module supply_watch_seq #(
    parameter int GLITCH_W0 = 4,
    parameter int GLITCH_W1 = 6,
    parameter int GLITCH_W2 = 10,
    parameter int GLITCH_W3 = 18,
    parameter int HOLD_T0   = 1,
    parameter int HOLD_T1   = 25,
    parameter int HOLD_T2   = 100,
    parameter int HOLD_T3   = 200
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       warn_uv,
    input  logic       rst_uv,
    input  logic       man_req,
    input  logic       fast_tick,
    input  logic       ms_tick,
    input  logic [1:0] glitch_sel,
    input  logic [1:0] hold_sel,
    output logic       bad_pwr_n,
    output logic       sys_rst_n
);
    localparam int NQ = 2;

    logic [NQ-1:0] uv_flags;
    logic [NQ-1:0] uv_faults;
    logic          rst_cause;
    logic          released;

    assign uv_flags = {rst_uv, warn_uv};

    for (genvar gi = 0; gi < NQ; gi++) begin : g_qual
        uv_qualifier #(
            .W0(GLITCH_W0), .W1(GLITCH_W1), .W2(GLITCH_W2), .W3(GLITCH_W3)
        ) u_qual (
            .clk     (clk),
            .por_n   (por_n),
            .tick_i  (fast_tick),
            .flag_i  (uv_flags[gi]),
            .sel_i   (glitch_sel),
            .fault_o (uv_faults[gi])
        );
    end

    assign rst_cause = uv_faults[1] | man_req;

    hold_timer #(
        .T0(HOLD_T0), .T1(HOLD_T1), .T2(HOLD_T2), .T3(HOLD_T3)
    ) u_hold (
        .clk        (clk),
        .por_n      (por_n),
        .tick_i     (ms_tick),
        .cause_i    (rst_cause),
        .sel_i      (hold_sel),
        .released_o (released)
    );

    always_comb begin
        sys_rst_n = released;
        bad_pwr_n = released & ~uv_faults[0];
    end

    AST_WARN_FAULT_SHOWS: assert property (@(posedge clk) disable iff (!por_n)
        (warn_uv && $past(warn_uv) && uv_faults[0]) |-> !bad_pwr_n); // R8

endmodule

// File: tb/sim_supply_watch_seq.sv
`timescale 1ns/1ps
module sim_supply_watch_seq;
    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic warn_uv = 1'b0, rst_uv = 1'b0, man_req = 1'b0;
    logic fast_tick = 1'b0, ms_tick = 1'b0;
    logic [1:0] glitch_sel = 2'd0, hold_sel = 2'd1;
    logic bad_pwr_n, sys_rst_n;

    always #2 clk = ~clk;

    supply_watch_seq u0 (
        .clk(clk), .por_n(por_n), .warn_uv(warn_uv), .rst_uv(rst_uv),
        .man_req(man_req), .fast_tick(fast_tick), .ms_tick(ms_tick),
        .glitch_sel(glitch_sel), .hold_sel(hold_sel),
        .bad_pwr_n(bad_pwr_n), .sys_rst_n(sys_rst_n)
    );

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;
    string cur_req = "R1";
    int ft_period = 1, ms_period = 1, tick_phase = 0;

    // Behavioural reference model
    int  m_run [2];
    bit  m_flt [2];
    bit  m_asserted;   // reset currently held by an active cause
    bit  m_counting;   // timeout running
    int  m_elapsed;

    function automatic int glitch_width(logic [1:0] s);
        case (s) 2'd0: return 4; 2'd1: return 6; 2'd2: return 10; default: return 18; endcase
    endfunction
    function automatic int hold_len(logic [1:0] s);
        case (s) 2'd0: return 1; 2'd1: return 25; 2'd2: return 100; default: return 200; endcase
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_run[0] = 0; m_run[1] = 0; m_flt[0] = 0; m_flt[1] = 0;
            m_asserted = 0; m_counting = 1; m_elapsed = 0;
        end else begin
            bit cause;
            cause = m_flt[1] || man_req;
            if (cause) begin
                m_asserted = 1; m_counting = 0; m_elapsed = 0;
            end else if (m_asserted) begin
                m_asserted = 0; m_counting = 1; m_elapsed = 0;
            end else if (m_counting && ms_tick) begin
                m_elapsed++;
                if (m_elapsed >= hold_len(hold_sel)) begin
                    m_counting = 0; m_elapsed = 0;
                end
            end
            for (int i = 0; i < 2; i++) begin
                bit f;
                f = (i == 0) ? warn_uv : rst_uv;
                if (!f) begin
                    m_run[i] = 0; m_flt[i] = 0;
                end else if (!m_flt[i]) begin
                    if (fast_tick) m_run[i]++;
                    if (m_run[i] >= glitch_width(glitch_sel)) begin
                        m_flt[i] = 1; m_run[i] = 0;
                    end
                end
            end
        end
    end

    // Tick generators
    always @(negedge clk) begin
        tick_phase++;
        fast_tick <= (tick_phase % ft_period) == 0;
        ms_tick   <= (tick_phase % ms_period) == 0;
    end

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cycles, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) begin
            bit e_rst;
            @(negedge clk);
            e_rst = !(m_asserted || m_counting);
            if (!por_n) e_rst = 0;
            check(cur_req, "sys_rst_n", sys_rst_n, e_rst);
            check((e_rst ? cur_req : "R8"), "bad_pwr_n", bad_pwr_n, e_rst && !m_flt[0]);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset state and first timeout
        cur_req = "R1";
        cyc(3);
        check("R1", "reset sys_rst_n", sys_rst_n, 1'b0);
        check("R1", "reset bad_pwr_n", bad_pwr_n, 1'b0);
        por_n = 1'b1;
        cyc(24);
        check("R1", "held before timeout", sys_rst_n, 1'b0);
        cyc(6);
        check("R1", "released after timeout", sys_rst_n, 1'b1);

        // R2/R3/R4: glitch widths, short pulses, immediate clear
        for (int s = 0; s < 4; s++) begin
            glitch_sel = 2'(s);
            cur_req = "R3";
            warn_uv = 1'b1; cyc(glitch_width(2'(s)) - 1);
            warn_uv = 1'b0; cyc(2);
            check("R3", "short dip ignored", bad_pwr_n, 1'b1);
            cur_req = "R2";
            warn_uv = 1'b1; cyc(glitch_width(2'(s)) + 1);
            check("R2", "qualified warning", bad_pwr_n, 1'b0);
            cur_req = "R4";
            warn_uv = 1'b0; cyc(1);
            check("R4", "warning clears", bad_pwr_n, 1'b1);
            cyc(2);
        end

        // R9: sparse fast ticks
        cur_req = "R9";
        ft_period = 3; glitch_sel = 2'd1;
        warn_uv = 1'b1; cyc(12); warn_uv = 1'b0; cyc(3);
        warn_uv = 1'b1; cyc(25); warn_uv = 1'b0; cyc(3);
        ft_period = 1;

        // R5/R6: reset level fault with each timeout, sparse ms ticks
        for (int s = 0; s < 4; s++) begin
            hold_sel = 2'(s); ms_period = (s == 3) ? 1 : 2;
            cur_req = "R5";
            rst_uv = 1'b1; cyc(8);
            check("R5", "reset from level fault", sys_rst_n, 1'b0);
            check("R8", "warning during reset", bad_pwr_n, 1'b0);
            cur_req = "R6";
            rst_uv = 1'b0; cyc(hold_len(2'(s)) * ms_period + 6);
            check("R6", "released after timeout", sys_rst_n, 1'b1);
        end

        // R7: manual request and cause returning during the timeout
        cur_req = "R7";
        hold_sel = 2'd1; ms_period = 1;
        man_req = 1'b1; cyc(2);
        check("R5", "manual reset", sys_rst_n, 1'b0);
        man_req = 1'b0; cyc(20);
        man_req = 1'b1; cyc(1); man_req = 1'b0; cyc(24);
        check("R7", "restarted timeout still held", sys_rst_n, 1'b0);
        cyc(3);
        // collision: cause returns in the last tick cycle
        man_req = 1'b1; cyc(1); man_req = 1'b0; cyc(25);
        man_req = 1'b1; cyc(1); man_req = 1'b0; cyc(30);
        // reset fault clears as manual request rises
        glitch_sel = 2'd0;
        rst_uv = 1'b1; cyc(6); rst_uv = 1'b0; man_req = 1'b1; cyc(3);
        man_req = 1'b0; cyc(30);

        // Mixed pseudo-random stimulus
        cur_req = "R7";
        hold_sel = 2'd0;
        for (int k = 0; k < 4000; k++) begin
            if ((k % 500) == 0) begin
                glitch_sel = 2'($urandom_range(0, 3));
                hold_sel   = 2'($urandom_range(0, 1));
                ft_period  = $urandom_range(1, 2);
                ms_period  = $urandom_range(1, 3);
            end
            if ($urandom_range(0, 9) == 0) warn_uv = ~warn_uv;
            if ($urandom_range(0, 11) == 0) rst_uv = ~rst_uv;
            man_req = ($urandom_range(0, 40) == 0);
            cyc(1);
        end
        warn_uv = 0; rst_uv = 0; man_req = 0;
        cyc(300);

        // R1 again: mid-run power-on reset
        cur_req = "R1";
        @(negedge clk); por_n = 1'b0;
        cyc(2);
        check("R1", "por asserts reset", sys_rst_n, 1'b0);
        por_n = 1'b1; cyc(5);
        finish_run();
    end
endmodule